// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block sits on the host side of a three-wire serial EEPROM link. A client presents one parallel request made of a command code, a word address and a write word. The master then runs the whole serial exchange on its own. It raises chip select and clocks out a start bit, a two-bit opcode, the address field and, where the command carries one, the data word. It produces the serial clock by dividing the system clock.

For a read, the master keeps clocking after the address. It drops the zero placeholder bit that the memory sends first, then gathers the data word. For any command that starts a self-timed program cycle, the master lowers chip select for a programmable minimum time and raises it again. It then watches the memory's data output until that output goes high. If the output stays low for too long, the master gives up and flags an error.

Requests use a simple handshake: one is accepted only while the busy output is low. Each request ends with a single-cycle done pulse, and for reads the returned word is valid at that pulse.

Top module: `eeprom3w_master`

## Requirements
- R1: Each frame is sent MSB first on `ee_di` as a 1 start bit, then the 2-bit opcode, then ADDR_W address bits, then DATA_W data bits for commands that carry data. `ee_di` is sampled by the memory on rising `ee_sk`, changes only while `ee_sk` is low, and is 0 during the read data phase.
- R2: The `req_cmd` codes map as follows. 0 = read, opcode 10, address from `req_addr`. 1 = write, opcode 01, with data. 2 = erase, opcode 11. For 3 = program enable, 4 = program disable, 5 = erase all and 6 = write all (with data), the opcode is 00 and the two address MSBs are 11, 00, 10 and 01 respectively; the remaining address bits are 0.
- R3: A read issues DATA_W more `ee_sk` pulses after the address, for 3+ADDR_W+DATA_W pulses in total. The controller samples `ee_do` when `ee_sk` falls. The sample taken as the last address bit ends is the zero placeholder and is discarded. `rd_data` holds the DATA_W following samples, first sample in the MSB.
- R4: `ee_sk` is high for CLK_DIV clocks at a time and is high only while `ee_cs` is high. `ee_cs` is high for exactly CLK_DIV clocks before the first rising `ee_sk`.
- R5: After write, erase, erase all or write all, `ee_cs` drops after the last frame bit and stays low for at least CS_LOW_CYC clocks. It then goes high, and `done` is asserted only once `ee_do` has been seen high.
- R6: If `ee_do` is not seen high within POLL_TIMEOUT clocks of polling, the request finishes with `done` and `timeout_err` = 1. `timeout_err` is 0 at any other completion and holds its value until the next accepted request.
- R7: A request is accepted only when `req_valid` is high and `req_busy` is low. A request presented while `req_busy` is high is ignored. `done` is asserted with `ee_cs` low.
- R8: Program enable and program disable finish right after their frame, with no chip-select toggle and no polling.
- R9: Code 7 is not a command. It causes `done` on the clock after acceptance, with no `ee_cs` or `ee_sk` activity and `timeout_err` = 0.
- R10: `rd_data` changes only at the completion of a read.
- R11: In reset, `ee_cs`, `ee_sk`, `ee_di`, `done`, `req_busy`, `timeout_err` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 3 | Command code (see R2, R9) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to program |
| req_busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| timeout_err | output | 1 | Busy polling timed out |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
Reads are run with returned words 0xA5C3, 0x8001, 0xFFFF and 0x0001. Swapped bit order, a placeholder bit that is kept, or sampling on the wrong clock edge each shift or corrupt at least one of these words in a visible way. Program commands are run with memory busy times of zero, short and long, plus one memory that never becomes ready. These cases show whether completion waits for the status, whether the chip-select low time is honoured, and whether the timeout fires only when it should. Every command code is framed once, including the four extended ones, so a wrong opcode or a wrong pseudo-address is caught directly.

// File: rtl/eeprom3w_master.sv
module eeprom3w_master #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int CLK_DIV      = 4,
  parameter int CS_LOW_CYC   = 8,
  parameter int POLL_TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout_err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int CW      = $clog2(FRAME_W + 1);
  localparam int RW      = $clog2(DATA_W + 1);
  localparam int DVW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int WMAX    = (CS_LOW_CYC > POLL_TIMEOUT) ? CS_LOW_CYC : POLL_TIMEOUT;
  localparam int WW      = $clog2(WMAX + 1);
  localparam logic [DVW-1:0] DIV_LAST  = DVW'(CLK_DIV - 1);
  localparam logic [WW-1:0]  GAP_LAST  = WW'(CS_LOW_CYC - 1);
  localparam logic [WW-1:0]  POLL_LAST = WW'(POLL_TIMEOUT - 1);
  localparam logic [CW-1:0]  NB_DATA   = CW'(FRAME_W);
  localparam logic [CW-1:0]  NB_HDR    = CW'(3 + ADDR_W);
  localparam logic [RW-1:0]  RD_BITS   = RW'(DATA_W);

  typedef enum logic [2:0] {IDLE, SEND, RECV, FIN, GAP, POLL} st_t;

  st_t               st;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]     bits;
  logic [RW-1:0]     rcnt;
  logic [DATA_W-1:0] rd_sh;
  logic [DVW-1:0]    div;
  logic [WW-1:0]     wcnt;
  logic              is_rd, is_pg;

  logic [1:0]        op_c, ext_c;
  logic              data_c, rd_c, pg_c, bad_c;
  logic [ADDR_W-1:0] addr_c;
  logic              tick;

  always_comb begin
    op_c = 2'b00; ext_c = 2'b00; data_c = 1'b0;
    rd_c = 1'b0;  pg_c = 1'b0;   bad_c = 1'b0;
    case (req_cmd)
      3'd0: begin op_c = 2'b10; rd_c = 1'b1; end
      3'd1: begin op_c = 2'b01; data_c = 1'b1; pg_c = 1'b1; end
      3'd2: begin op_c = 2'b11; pg_c = 1'b1; end
      3'd3: ext_c = 2'b11;
      3'd4: ext_c = 2'b00;
      3'd5: begin ext_c = 2'b10; pg_c = 1'b1; end
      3'd6: begin ext_c = 2'b01; data_c = 1'b1; pg_c = 1'b1; end
      default: bad_c = 1'b1;
    endcase
    addr_c = (op_c == 2'b00) ? (ADDR_W'(ext_c) << (ADDR_W - 2)) : req_addr;
  end

  assign tick     = (div == DIV_LAST);
  assign req_busy = (st != IDLE);
  assign ee_di    = ee_cs & sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sh <= '0; bits <= '0; rcnt <= '0; rd_sh <= '0;
      div <= '0; wcnt <= '0; is_rd <= 1'b0; is_pg <= 1'b0;
      done <= 1'b0; rd_data <= '0; timeout_err <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          timeout_err <= 1'b0;
          if (bad_c) done <= 1'b1;
          else begin
            st    <= SEND;
            ee_cs <= 1'b1;
            sh    <= {1'b1, op_c, addr_c, data_c ? req_wdata : {DATA_W{1'b0}}};
            bits  <= data_c ? NB_DATA : NB_HDR;
            is_rd <= rd_c;
            is_pg <= pg_c;
            div   <= '0;
          end
        end
        SEND, RECV: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!ee_sk) ee_sk <= 1'b1;
            else begin
              ee_sk <= 1'b0;
              if (st == SEND) begin
                sh   <= sh << 1;
                bits <= bits - 1'b1;
                if (bits == CW'(1)) begin
                  if (is_rd) begin
                    st   <= RECV;
                    rcnt <= RD_BITS;
                  end else begin
                    ee_cs <= 1'b0;
                    if (is_pg) begin
                      st   <= GAP;
                      wcnt <= '0;
                    end else begin
                      st   <= IDLE;
                      done <= 1'b1;
                    end
                  end
                end
              end else begin
                rd_sh <= {rd_sh[DATA_W-2:0], ee_do};
                rcnt  <= rcnt - 1'b1;
                if (rcnt == RW'(1)) begin
                  ee_cs <= 1'b0;
                  st    <= FIN;
                end
              end
            end
          end
        end
        FIN: begin
          rd_data <= rd_sh;
          done    <= 1'b1;
          st      <= IDLE;
        end
        GAP: begin
          if (wcnt == GAP_LAST) begin
            ee_cs <= 1'b1;
            st    <= POLL;
            wcnt  <= '0;
          end else wcnt <= wcnt + 1'b1;
        end
        POLL: begin
          if (ee_do) begin
            ee_cs <= 1'b0;
            done  <= 1'b1;
            st    <= IDLE;
          end else if (wcnt == POLL_LAST) begin
            ee_cs       <= 1'b0;
            done        <= 1'b1;
            timeout_err <= 1'b1;
            st          <= IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R1
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R7
  done_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sk));

  // R7
  cs_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> ($past(req_valid) || $past(st == GAP)));

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);

endmodule

// File: tb/tb_eeprom3w_master.sv
module tb_eeprom3w_master;
  localparam int AW = 8, DW = 16, DIV = 2, CSL = 5, PTO = 300;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_busy, done, timeout_err, ee_cs, ee_sk, ee_di;
  logic [DW-1:0] rd_data;
  logic ee_do = 0;

  eeprom3w_master #(.ADDR_W(AW), .DATA_W(DW), .CLK_DIV(DIV),
                    .CS_LOW_CYC(CSL), .POLL_TIMEOUT(PTO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  always #5 clk = ~clk;

  typedef struct {
    int cmd; logic [63:0] bits; int nbits;
    logic [DW-1:0] rd; int busy; bit never;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_prog(int c);
    return c == 1 || c == 2 || c == 5 || c == 6;
  endfunction

  // expected frame per R1/R2
  function automatic item_t mk(int cmd, logic [AW-1:0] a, logic [DW-1:0] w);
    item_t it;
    logic [1:0] op, ex;
    logic [AW-1:0] af;
    int withd;
    op = 2'b00; ex = 2'b00; withd = 0;
    case (cmd)
      0: op = 2'b10;
      1: begin op = 2'b01; withd = 1; end
      2: op = 2'b11;
      3: ex = 2'b11;
      4: ex = 2'b00;
      5: ex = 2'b10;
      6: begin ex = 2'b01; withd = 1; end
      default: ;
    endcase
    af = (cmd >= 3) ? {ex, {(AW-2){1'b0}}} : a;
    it.cmd = cmd; it.rd = '0; it.busy = 0; it.never = 0;
    if (cmd == 7) begin it.bits = '0; it.nbits = 0; end
    else begin
      it.bits = {59'd0, 1'b1, op, 2'b00} >> 2;
      it.bits = (it.bits << AW) | 64'(af);
      it.nbits = 3 + AW;
      if (withd == 1 || cmd == 0) begin
        it.bits = (it.bits << DW) | ((withd == 1) ? 64'(w) : 64'd0);
        it.nbits += DW;
      end
    end
    return it;
  endfunction

  task automatic send(int cmd, logic [AW-1:0] a, logic [DW-1:0] w,
                      logic [DW-1:0] rd, int busy, bit never);
    item_t it;
    it = mk(cmd, a, w);
    it.rd = rd; it.busy = busy; it.never = never;
    @(negedge clk);
    while (req_busy) @(negedge clk);
    q.push_back(it);
    req_cmd = 3'(cmd); req_addr = a; req_wdata = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / memory model
  logic prev_sk = 0, prev_cs = 0, rd_do = 0;
  logic [63:0] cap = '0;
  logic [DW-1:0] last_rd = '0;
  int rise_idx = 0, hi_w = 0, setup = 0, phase = 0, busy_left = 0, low_cnt = 0;
  bit sk_bad = 0, low_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() == 0) begin
        if (ee_cs || done)
          chk(0, "R7", "activity without accepted request cs/done", {ee_cs, done}, 0);
      end else begin
        item_t it;
        it = q[0];
        if (ee_sk && !prev_sk) begin
          cap = {cap[62:0], ee_di};
          if (rise_idx == 0)
            chk(setup == DIV, "R4", "cs setup before first sk", setup, DIV);
          if (it.cmd == 0) begin
            if (rise_idx == 3 + AW - 1) rd_do = 1'b0;
            else if (rise_idx >= 3 + AW && rise_idx < 3 + AW + DW)
              rd_do = it.rd[DW - 1 - (rise_idx - 3 - AW)];
          end
          rise_idx++;
          hi_w = 1;
        end else if (ee_sk) hi_w++;
        if (!ee_sk && prev_sk && hi_w != DIV) sk_bad = 1;
        if (ee_cs && !ee_sk && rise_idx == 0) setup++;
        if (!ee_cs && prev_cs && phase == 0 && is_prog(it.cmd)) begin
          phase = 1; busy_left = it.busy; low_cnt = 0;
        end
        if (phase == 1) begin
          if (!ee_cs) low_cnt++;
          if (ee_cs && !prev_cs && low_cnt < CSL) low_bad = 1;
          if (busy_left > 0) busy_left--;
        end
        if (done) begin
          chk(rise_idx == it.nbits, "R1", $sformatf("sk pulse count cmd %0d", it.cmd), rise_idx, it.nbits);
          chk(cap == it.bits, "R2", $sformatf("frame bits cmd %0d", it.cmd), cap, it.bits);
          chk(!sk_bad, "R4", "sk high width", sk_bad, 0);
          chk(timeout_err == it.never, "R6", "timeout_err at done", timeout_err, it.never);
          if (it.cmd == 0) begin
            chk(rd_data == it.rd, "R3", "read word", rd_data, it.rd);
            last_rd = it.rd;
          end else
            chk(rd_data == last_rd, "R10", "rd_data held", rd_data, last_rd);
          if (is_prog(it.cmd)) begin
            chk(phase == 1 && !low_bad, "R5", "cs low time before poll", low_cnt, CSL);
            if (!it.never)
              chk(busy_left == 0, "R5", "done only after ready", busy_left, 0);
          end else
            chk(phase == 0, "R8", $sformatf("no poll for cmd %0d", it.cmd), phase, 0);
          if (it.cmd == 7)
            chk(rise_idx == 0 && setup == 0, "R9", "no bus activity", setup, 0);
          void'(q.pop_front());
          cap = '0; rise_idx = 0; hi_w = 0; setup = 0; phase = 0;
          busy_left = 0; low_cnt = 0; sk_bad = 0; low_bad = 0; rd_do = 0;
        end
      end
      ee_do = (phase == 1) ? (busy_left == 0 && !(q.size() != 0 && q[0].never)) : rd_do;
      prev_sk = ee_sk; prev_cs = ee_cs;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({ee_cs, ee_sk, ee_di, done, req_busy, timeout_err} == 0, "R11", "outputs in reset",
        {ee_cs, ee_sk, ee_di, done, req_busy, timeout_err}, 0);
    chk(rd_data == 0, "R11", "rd_data in reset", rd_data, 0);
    rst_n = 1;
    send(3, 8'h00, 16'h0000, 16'h0, 0, 0);
    send(1, 8'h5A, 16'h1234, 16'h0, 20, 0);
    send(0, 8'h5A, 16'h0000, 16'hA5C3, 0, 0);
    send(2, 8'hFF, 16'h0000, 16'h0, 8, 0);
    send(5, 8'h3C, 16'h0000, 16'h0, 30, 0);
    send(6, 8'h81, 16'hBEEF, 16'h0, 12, 0);
    send(0, 8'h00, 16'h0000, 16'h8001, 0, 0);
    send(1, 8'h01, 16'h8000, 16'h0, 0, 0);
    send(1, 8'h7E, 16'h5555, 16'h0, 0, 1);
    send(4, 8'hAA, 16'hFFFF, 16'h0, 0, 0);
    send(7, 8'h12, 16'h3456, 16'h0, 0, 0);
    send(0, 8'hC3, 16'h0000, 16'hFFFF, 0, 0);
    send(0, 8'h80, 16'h0000, 16'h0001, 0, 0);
    // R7: request presented while busy is ignored
    begin
      item_t it;
      it = mk(2, 8'h44, 16'h0);
      it.busy = 40;
      @(negedge clk);
      q.push_back(it);
      req_cmd = 3'd2; req_addr = 8'h44; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      repeat (6) @(negedge clk);
      chk(req_busy == 1, "R7", "busy during erase", req_busy, 1);
      req_cmd = 3'd0; req_addr = 8'h11; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      while (q.size() != 0) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(!ee_cs && !req_busy, "R7", "ignored request left no transaction",
          {ee_cs, req_busy}, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule